// File: doc/BRIEF.md
# Power-Management Event Status and Enable Unit

This unit collects wake and power-management requests from peripheral sources and turns them into a single request line for the system. Each source delivers a one-cycle pulse. The pulse latches a sticky flag in a 32-bit status register. A matching 32-bit enable register selects which flags may reach the output. The combined output is raised one clock after any flag and the enable bit at the same position are both high.

Software reaches both registers through a simple single-cycle register bus. The bus has an address, a write strobe, write data and combinational read data. Flags are cleared by writing ones to them. The enable register is split into two domains. The upper byte belongs to the standby domain. The lower 24 bits belong to the working domain and are wiped for as long as the standby indication is held.

Status bits 0 to 5 take the interrupt-controller interrupt, the interrupt-controller SMI, SMBus, UART 1, UART 2 and USB controller 1, in that order. Bits 24 to 31 take the eight GPIO mapper event lines, with line 7 on bit 31.

Top module: `pme_gate_unit`

## Requirements
- R1: After reset, both registers read 00000000h and `pme_out` is low.
- R2: A write at offset 1Ch stores all 32 bits of write data into the enable register, and later reads at 1Ch return exactly that value, unless R3 applies.
- R3: In every cycle in which `standby` is high, enable bits [23:0] become zero. This takes precedence over a write in the same cycle. Bits [31:24] keep their value or take the written value.
- R4: An event pulse on `evt_in[i]` sets status bit i at offset 18h for the implemented bits (0 to 5 and 24 to 31). The bit stays set across later cycles with no event.
- R5: Writing a 1 to a status bit at offset 18h clears it. Writing a 0 leaves it unchanged.
- R6: When an event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R7: `pme_out` is high in the cycle after one in which some status bit and the enable bit at the same position were both high, and low otherwise.
- R8: Status bits 6 to 23 always read as zero. Events on those positions have no effect.
- R9: Any address other than 18h and 1Ch reads zero, and writes to it change neither register.
- R10: `bus_rdata` reflects the addressed register in the same cycle as the address, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| evt_in | input | 32 | Event pulses, one bit per source |
| standby | input | 1 | Standby indication, clears working-domain enables |
| pme_out | output | 1 | Registered combined event request |

## Verification
The assertions assume that `evt_in`, `standby` and the bus signals are synchronous to `clk` and stable around its rising edge. They also assume that reset is applied from time zero. The bench drives every input on the falling edge and samples half a period later. This keeps all stimulus inside those assumptions. Random event vectors are made sparse by AND-ing several draws, so flags build up over time instead of saturating. Standby is drawn rarely, so enable values survive long enough to gate the output. Unmapped addresses are drawn often enough to exercise the ignored-write path.

// File: rtl/pme_pkg.sv
package pme_pkg;

  localparam int unsigned REG_W = 32;

  typedef logic [REG_W-1:0] word_t;

  // Bits below n set, the rest clear.
  function automatic word_t low_mask(input int unsigned n);
    word_t m;
    m = '0;
    for (int unsigned i = 0; i < REG_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Sticky flag update: capture wins over a same-cycle clear.
  function automatic word_t flag_update(input word_t cur, input word_t set_v,
                                        input word_t clr_v, input word_t impl);
    return ((cur & ~clr_v) | set_v) & impl;
  endfunction

  // Enable update: write first, then the standby wipe of the working domain.
  function automatic word_t enable_update(input word_t cur, input word_t wdata,
                                          input logic wr, input logic stby,
                                          input word_t work_m);
    word_t nxt;
    nxt = wr ? wdata : cur;
    if (stby) nxt = nxt & ~work_m;
    return nxt;
  endfunction

endpackage

// File: rtl/pme_addr_decode.sv
module pme_addr_decode #(
  parameter int unsigned     ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] STS_OFF = 8'h18,
  parameter logic [ADDR_W-1:0] EN_OFF  = 8'h1C
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                we,
  input  logic [pme_pkg::REG_W-1:0] wdata,
  input  logic [pme_pkg::REG_W-1:0] sts_val,
  input  logic [pme_pkg::REG_W-1:0] en_val,
  output logic                en_wr,
  output logic [pme_pkg::REG_W-1:0] sts_clr,
  output logic [pme_pkg::REG_W-1:0] rdata
);
  logic hit_sts;
  logic hit_en;

  assign hit_sts = (addr == STS_OFF);
  assign hit_en  = (addr == EN_OFF);
  assign en_wr   = we && hit_en;
  assign sts_clr = (we && hit_sts) ? wdata : '0;

  always_comb begin
    unique case (1'b1)
      hit_sts: rdata = sts_val;
      hit_en:  rdata = en_val;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pme_flag_bank.sv
module pme_flag_bank #(
  parameter logic [pme_pkg::REG_W-1:0] IMPL_MASK = 32'hFF00_003F
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [pme_pkg::REG_W-1:0] set_v,
  input  logic [pme_pkg::REG_W-1:0] clr_v,
  output logic [pme_pkg::REG_W-1:0] flags
);
  import pme_pkg::*;

  word_t flags_nxt;

  assign flags_nxt = flag_update(flags, set_v, clr_v, IMPL_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_nxt;
  end
endmodule

// File: rtl/pme_enable_reg.sv
module pme_enable_reg #(
  parameter int unsigned WORK_BITS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic stby,
  input  logic [pme_pkg::REG_W-1:0] wdata,
  output logic [pme_pkg::REG_W-1:0] en
);
  import pme_pkg::*;

  localparam word_t WORK_MASK = low_mask(WORK_BITS);

  word_t en_nxt;

  assign en_nxt = enable_update(en, wdata, wr, stby, WORK_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) en <= '0;
    else        en <= en_nxt;
  end
endmodule

// File: rtl/pme_combine.sv
module pme_combine (
  input  logic clk,
  input  logic rst_n,
  input  logic [pme_pkg::REG_W-1:0] flags,
  input  logic [pme_pkg::REG_W-1:0] en,
  output logic hit,
  output logic req_q
);
  assign hit = |(flags & en);

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= hit;
  end
endmodule

// File: rtl/pme_gate_unit.sv
module pme_gate_unit #(
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STS_OFF   = 8'h18,
  parameter logic [ADDR_W-1:0] EN_OFF    = 8'h1C,
  parameter int unsigned       WORK_BITS = 24,
  parameter logic [31:0]       IMPL_MASK = 32'hFF00_003F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       evt_in,
  input  logic              standby,
  output logic              pme_out
);
  import pme_pkg::*;

  // Named internal events, visible to the checker.
  word_t flags_q;
  word_t en_q;
  word_t clr_vec;
  logic  en_wr;
  logic  any_hit;

  pme_addr_decode #(
    .ADDR_W (ADDR_W),
    .STS_OFF(STS_OFF),
    .EN_OFF (EN_OFF)
  ) u_dec (
    .addr   (bus_addr),
    .we     (bus_we),
    .wdata  (bus_wdata),
    .sts_val(flags_q),
    .en_val (en_q),
    .en_wr  (en_wr),
    .sts_clr(clr_vec),
    .rdata  (bus_rdata)
  );

  pme_flag_bank #(.IMPL_MASK(IMPL_MASK)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set_v(evt_in),
    .clr_v(clr_vec),
    .flags(flags_q)
  );

  pme_enable_reg #(.WORK_BITS(WORK_BITS)) u_en (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (en_wr),
    .stby (standby),
    .wdata(bus_wdata),
    .en   (en_q)
  );

  pme_combine u_comb (
    .clk  (clk),
    .rst_n(rst_n),
    .flags(flags_q),
    .en   (en_q),
    .hit  (any_hit),
    .req_q(pme_out)
  );
endmodule

// File: rtl/pme_gate_unit_chk.sv
module pme_gate_unit_chk #(
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STS_OFF   = 8'h18,
  parameter logic [ADDR_W-1:0] EN_OFF    = 8'h1C,
  parameter int unsigned       WORK_BITS = 24,
  parameter logic [31:0]       IMPL_MASK = 32'hFF00_003F
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       evt_in,
  input logic              standby,
  input logic              pme_out,
  input logic [31:0]       flags_q,
  input logic [31:0]       en_q,
  input logic              any_hit
);
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == EN_OFF && !standby) |=> (en_q == $past(bus_wdata))); // R2

  AST_STBY_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (en_q[WORK_BITS-1:0] == '0)); // R3

  AST_STBY_KEEP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !(bus_we && bus_addr == EN_OFF)) |=>
      (en_q[31:WORK_BITS] == $past(en_q[31:WORK_BITS]))); // R3

  AST_EVENT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(evt_in & IMPL_MASK)) == $past(evt_in & IMPL_MASK))); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == STS_OFF) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R4

  AST_PME_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pme_out == $past(any_hit))); // R7

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STS_OFF) |-> ((bus_rdata & ~IMPL_MASK) == '0)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != STS_OFF && bus_addr != EN_OFF) |-> (bus_rdata == '0)); // R9
endmodule

bind pme_gate_unit pme_gate_unit_chk #(
  .ADDR_W   (ADDR_W),
  .STS_OFF  (STS_OFF),
  .EN_OFF   (EN_OFF),
  .WORK_BITS(WORK_BITS),
  .IMPL_MASK(IMPL_MASK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .evt_in   (evt_in),
  .standby  (standby),
  .pme_out  (pme_out),
  .flags_q  (flags_q),
  .en_q     (en_q),
  .any_hit  (any_hit)
);

// File: tb/pme_gate_unit_test.sv
module pme_gate_unit_test;
  localparam logic [31:0] IMPL = 32'hFF00_003F;
  localparam logic [7:0]  A_STS = 8'h18;
  localparam logic [7:0]  A_EN  = 8'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] evt = '0;
  logic        stby = 1'b0;
  logic [31:0] rdata;
  logic        pme;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] m_flag = '0;
  logic [31:0] m_en = '0;
  logic        m_pme = 1'b0;

  always #10 clk = ~clk;

  pme_gate_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .evt_in(evt), .standby(stby), .pme_out(pme)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == A_STS) return m_flag;
    if (a == A_EN)  return m_en;
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == A_STS) return "R4";
    if (a == A_EN)  return "R2";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, check, then advance the model.
  task automatic step(input string req, input logic [7:0] a, input logic w,
                      input logic [31:0] d, input logic [31:0] e, input logic s);
    @(negedge clk);
    addr = a; we = w; wdata = d; evt = e; stby = s;
    #1;
    check(req, rdata, exp_read(a));
    check("R7", {31'h0, pme}, {31'h0, m_pme});
    m_pme = |(m_flag & m_en);
    if (w && a == A_STS) m_flag = m_flag & ~d;
    m_flag = (m_flag | e) & IMPL;
    if (w && a == A_EN) m_en = d;
    if (s) m_en[23:0] = 24'h0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    addr = A_STS; #1; check("R1", rdata, 32'h0);
    addr = A_EN;  #1; check("R1", rdata, 32'h0);
    check("R1", {31'h0, pme}, 32'h0);
    rst_n = 1'b1;

    // Directed corner cases
    step("R2", A_EN, 1, 32'hA5A5_5A5A, 0, 0);
    step("R2", A_EN, 0, 0, 0, 0);
    step("R4", A_STS, 0, 0, 32'h0100_0001, 0);
    step("R4", A_STS, 0, 0, 0, 0);
    step("R4", A_STS, 0, 0, 0, 0);
    step("R5", A_STS, 1, 32'h0000_0000, 0, 0);
    step("R5", A_STS, 0, 0, 0, 0);
    step("R6", A_STS, 1, 32'h0000_0001, 32'h0000_0001, 0);
    step("R6", A_STS, 0, 0, 0, 0);
    step("R5", A_STS, 1, 32'hFFFF_FFFF, 0, 0);
    step("R5", A_STS, 0, 0, 0, 0);
    step("R8", A_STS, 0, 0, 32'h00FF_FFC0, 0);
    step("R8", A_STS, 0, 0, 0, 0);
    step("R9", 8'h20, 1, 32'hFFFF_FFFF, 0, 0);
    step("R9", 8'h20, 0, 0, 0, 0);
    step("R9", A_EN, 0, 0, 0, 0);
    step("R3", A_EN, 1, 32'hFFFF_FFFF, 0, 1);
    step("R3", A_EN, 0, 0, 0, 0);
    step("R10", A_STS, 0, 0, 32'h8000_0000, 0);
    step("R10", A_EN, 0, 0, 0, 0);
    step("R10", A_STS, 0, 0, 0, 0);

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [7:0]  ra;
      int unsigned pick;
      pick = $urandom % 8;
      if (pick < 3)      ra = A_STS;
      else if (pick < 6) ra = A_EN;
      else               ra = 8'($urandom);
      step(tag_of(ra), ra, ($urandom % 2) == 0, $urandom,
           $urandom & $urandom & $urandom & $urandom, ($urandom % 16) == 0);
    end
    step(tag_of(A_EN), A_EN, 0, 0, 0, 0);
    summary();
  end
endmodule